// File: doc/BRIEF.md
# Shift-Register FIFO with Occupancy Counter

This block is a single-clock synchronous FIFO whose storage is a chain of per-bit shift registers rather than a dual-port memory. Every accepted write shifts the new word into tap 0 and pushes each older word one tap deeper. Stored words never move toward a read pointer. Instead, one up/down occupancy counter acts as the read tap address and also yields the empty and full flags.

The counter resets to all ones, which stands for minus one, meaning nothing is stored. It is two bits wider than the tap address. Its top bit marks empty. Its low bits select the tap holding the oldest word, and that tap drives the read data combinationally. A pop consumes the word currently shown. A write into a full FIFO without a matching read is dropped, and so is a read from an empty FIFO. Each of these events sets a sticky error flag that only reset clears.

The word width and the depth exponent are parameters; the depth is 2^ADDR_W (16 by default). Reset is synchronous.

Top module: `sfifo_srl`

## Requirements
- R1: While and after a synchronous reset, `empty` is 1, `full` is 0, `overflow` is 0 and `underflow` is 0.
- R2: Words leave in the order they were accepted. Whenever `empty` is 0, `rd_data` shows the oldest stored word in the same cycle, and a pop removes exactly that word.
- R3: A push without a pop adds one word. After DEPTH (16 by default) such pushes from empty, `full` is 1 and stays 1 until a word is removed.
- R4: A pop without a push on a non-empty FIFO removes one word. `empty` becomes 1 in the cycle after the last stored word is popped.
- R5: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave the occupancy unchanged. On the next cycle `rd_data` shows the next-oldest word.
- R6: A push without a pop while `full` is 1 is ignored: contents and occupancy are unchanged, and `overflow` becomes 1 on the next cycle.
- R7: A pop while `empty` is 1 is ignored and sets `underflow` on the next cycle. If a push arrives in the same cycle, the push is still accepted.
- R8: A push and a pop in the same cycle while `full` is 1 are both accepted. `full` stays 1, no error flag is set, and word order is kept.
- R9: `overflow` and `underflow` stay at 1 until reset, whatever later traffic occurs.
- R10: `empty` and `full` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| pop | input | 1 | Read request; consumes the word on rd_data |
| rd_data | output | WIDTH | Oldest stored word, combinational |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a pop was dropped |

## Verification
The FIFO is exercised in several ways, each aimed at a different part of the design:
- A straight fill to full followed by a full drain exposes tap-selection errors at every counter value, including the all-ones reset value and the top address.
- Interleaved bursts and simultaneous push/pop at mid occupancy separate a correct hold of the counter from an off-by-one between shift and tap.
- Pushes at full, with and without a pop, check that the drop decision depends on the pop.
- Pops at empty, with and without a push, check the same for the read side.
- A final run of legal traffic followed by a reset shows that the error flags hold until reset and clear only then.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_INC  = 2'd1,
    OCC_DEC  = 2'd2
  } occ_op_e;

  // Counter action from the accepted push/pop pair.
  function automatic occ_op_e occ_decode(input logic push_ok, input logic pop_ok);
    if (push_ok && !pop_ok)      return OCC_INC;
    else if (pop_ok && !push_ok) return OCC_DEC;
    else                         return OCC_HOLD;
  endfunction

  // A pop is taken only when something is stored.
  function automatic logic pop_accept(input logic pop, input logic empty);
    return pop && !empty;
  endfunction

  // A push is taken unless full, or when a pop frees the slot in the same cycle.
  function automatic logic push_accept(input logic push, input logic full, input logic pop_ok);
    return push && (!full || pop_ok);
  endfunction

endpackage

// File: rtl/sfifo_lane.sv
module sfifo_lane #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              shift,
  input  logic              din,
  input  logic [ADDR_W-1:0] tap,
  output logic              dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (shift) chain <= {chain[DEPTH-2:0], din};
  end

  assign dout = chain[tap];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int WIDTH  = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              shift,
  input  logic [WIDTH-1:0]  din,
  input  logic [ADDR_W-1:0] tap,
  output logic [WIDTH-1:0]  dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    sfifo_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk  (clk),
      .shift(shift),
      .din  (din[b]),
      .tap  (tap),
      .dout (dout[b])
    );
  end
endmodule

// File: rtl/sfifo_occ.sv
module sfifo_occ
  import sfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W-1:0] tap
);
  localparam int CW    = ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CW-1:0] TOP = CW'(DEPTH - 1);

  logic [CW-1:0] cnt;
  occ_op_e       op;

  assign empty   = cnt[CW-1];
  assign full    = !empty && (cnt == TOP);
  assign tap     = cnt[ADDR_W-1:0];
  assign pop_ok  = pop_accept(pop, empty);
  assign push_ok = push_accept(push, full, pop_ok);
  assign op      = occ_decode(push_ok, pop_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else begin
      case (op)
        OCC_INC: cnt <= cnt + CW'(1);
        OCC_DEC: cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_errs.sv
module sfifo_errs (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic full,
  input  logic empty,
  output logic ovf_evt,
  output logic udf_evt,
  output logic overflow,
  output logic underflow
);
  assign ovf_evt = push && full && !pop;
  assign udf_evt = pop && empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (ovf_evt) overflow  <= 1'b1;
      if (udf_evt) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/sfifo_srl.sv
module sfifo_srl #(
  parameter int WIDTH  = 24,
  parameter int ADDR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  logic              push_ok;
  logic              pop_ok;
  logic [ADDR_W-1:0] tap;
  logic              ovf_evt;
  logic              udf_evt;

  sfifo_occ #(.ADDR_W(ADDR_W)) u_occ (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .pop    (pop),
    .push_ok(push_ok),
    .pop_ok (pop_ok),
    .empty  (empty),
    .full   (full),
    .tap    (tap)
  );

  sfifo_store #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .shift(push_ok),
    .din  (wr_data),
    .tap  (tap),
    .dout (rd_data)
  );

  sfifo_errs u_errs (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .full     (full),
    .empty    (empty),
    .ovf_evt  (ovf_evt),
    .udf_evt  (udf_evt),
    .overflow (overflow),
    .underflow(underflow)
  );
endmodule

// File: rtl/sfifo_srl_chk.sv
module sfifo_srl_chk (
  input logic clk,
  input logic rst,
  input logic push,
  input logic pop,
  input logic empty,
  input logic full,
  input logic overflow,
  input logic underflow,
  input logic push_ok,
  input logic pop_ok
);
  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (empty && !full && !overflow && !underflow)); // R1
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst) (empty && push) |=> !empty); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (full && push && !pop) |=> (full && overflow)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (full && push && !pop) |-> !push_ok); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (empty && pop) |-> !pop_ok); // R7
  AST_UDF_SET: assert property (@(posedge clk) disable iff (rst) (empty && pop) |=> underflow); // R7
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst) (full && push && pop) |=> (full && $stable(overflow))); // R8
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst) (!empty && !full && push && pop) |=> ($stable(empty) && $stable(full))); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R9
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst) underflow |=> underflow); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(empty && full)); // R10
endmodule

bind sfifo_srl sfifo_srl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .push     (push),
  .pop      (pop),
  .empty    (empty),
  .full     (full),
  .overflow (overflow),
  .underflow(underflow),
  .push_ok  (push_ok),
  .pop_ok   (pop_ok)
);

// File: tb/sfifo_srl_test.sv
module sfifo_srl_test;
  localparam int PERIOD = 10;
  localparam int WIDTH  = 24;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             push = 1'b0;
  logic             pop = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             empty, full, overflow, underflow;

  int checks = 0;
  int fails  = 0;

  logic [WIDTH-1:0] q[$];
  logic m_ovf = 1'b0;
  logic m_udf = 1'b0;

  sfifo_srl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .push(push), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .empty(empty), .full(full),
    .overflow(overflow), .underflow(underflow)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare all outputs with the model; called away from clock edges.
  task automatic chk_state(input string tag);
    chk({tag, " empty"}, 32'(empty), 32'(q.size() == 0));
    chk({tag, " full"}, 32'(full), 32'(q.size() == DEPTH));
    chk({tag, " overflow"}, 32'(overflow), 32'(m_ovf));
    chk({tag, " underflow"}, 32'(underflow), 32'(m_udf));
    if (q.size() != 0) chk({tag, " rd_data"}, 32'(rd_data), 32'(q[0]));
  endtask

  // Drive one cycle at the falling edge, update the model after the rising edge.
  task automatic step(input logic ps, input logic pp, input logic [WIDTH-1:0] d);
    logic ap, apu;
    @(negedge clk);
    push = ps; pop = pp; wr_data = d;
    @(posedge clk);
    ap  = pp && (q.size() > 0);
    apu = ps && ((q.size() < DEPTH) || ap);
    if (ps && q.size() == DEPTH && !pp) m_ovf = 1'b1;
    if (pp && q.size() == 0) m_udf = 1'b1;
    if (ap) void'(q.pop_front());
    if (apu) q.push_back(d);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    m_ovf = 1'b0;
    m_udf = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1 reset");
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, WIDTH'(24'hA00000 + i * 24'h111));
      chk_state("R3 fill");
    end
    chk("R3 full after DEPTH pushes", 32'(full), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 order", 32'(rd_data), 32'(24'hA00000 + i * 24'h111));
      step(1'b0, 1'b1, '0);
      chk_state("R4 drain");
    end
    chk("R4 empty after drain", 32'(empty), 32'd1);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, WIDTH'(24'h5A0000 + i));
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, WIDTH'(24'h330000 + i * 7));
      chk_state("R5 push+pop mid");
    end
    for (int i = 0; i < 7; i++) begin
      step(i % 2 == 0, 1'b1, WIDTH'(24'h0F0F00 + i));
      chk_state("R2 interleave");
    end
    while (q.size() > 0) step(1'b0, 1'b1, '0);
    chk_state("R4 empty again");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, WIDTH'(24'hC00000 + i));
    step(1'b1, 1'b0, 24'hDEAD01);
    chk("R6 overflow set", 32'(overflow), 32'd1);
    chk_state("R6 push at full dropped");
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, WIDTH'(24'hE00000 + i));
      chk_state("R8 push+pop at full");
    end
    for (int i = 0; i < DEPTH; i++) begin
      chk_state("R6 contents after drop");
      step(1'b0, 1'b1, '0);
    end
    chk_state("R9 overflow holds");
  endtask

  task automatic t_underflow();
    step(1'b0, 1'b1, '0);
    chk("R7 underflow set", 32'(underflow), 32'd1);
    chk_state("R7 pop at empty");
    step(1'b1, 1'b1, 24'h777777);
    chk_state("R7 push accepted with empty pop");
    chk("R7 word kept", 32'(rd_data), 32'h777777);
    step(1'b0, 1'b1, '0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, WIDTH'(i));
    while (q.size() > 0) step(1'b0, 1'b1, '0);
    chk_state("R9 both flags hold");
    do_reset();
    chk_state("R9 reset clears flags");
  endtask

  initial begin
    t_reset();
    t_fill_drain();
    t_mixed();
    t_overflow();
    t_underflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule